// File: doc/BRIEF.md
# Cache-as-RAM Mode Controller

This block sits around a small set-associative cache data array. It adds a scratch-memory mode in which a fixed address window maps straight onto the data storage, so the array can serve as working RAM before main memory has been brought up. In the normal mode the array acts as a simple write-allocating cache for the CPU. Line fills and evictions of valid lines are handled outside this block, so a write that finds no hit and no free way is refused with an error.

A pulse on `mode_enter_i` starts a flush walker. The walker steps through every line with the set index as the major order, writes back dirty lines over a valid/ready port, and invalidates each line. When the walk is complete the scratch mode is reported active. In that mode, addresses inside the window index the data array directly: the low offset bits select the set and the upper offset bits select the way. Tags and valid bits are never read or written. Both the CPU port and a second agent port (for example a DMA engine) may use the window. A pulse on `mode_leave_i` returns the block to normal mode within one cycle and does no flush, because every line is still marked invalid.

Top module: `car_ram_ctrl`

## Requirements
- R1: After reset `car_active_o`, `busy_o`, `wb_valid_o` and both response-valid outputs are 0. While the mode is active, no line is ever marked valid.
- R2: In normal mode, an enter pulse raises `busy_o` in the following cycle. `car_active_o` rises only in the cycle after the last line has been handled, and `busy_o` and `car_active_o` are never high together.
- R3: The flush visits line index set*WAYS+way in ascending order. A clean line takes one cycle. A dirty line drives `wb_valid_o` with `wb_addr_o` = {tag, set} and `wb_data_o` held stable until `wb_ready_o` is seen, so a flush lasts SETS*WAYS cycles plus the cycles with `wb_ready_o` low.
- R4: After a flush every line is invalid, so in normal mode a read of an address that was cached before the flush returns an error.
- R5: While the mode is active, a window address at offset o = way*SETS + set (the offset is the low log2(SETS*WAYS) address bits, and the window base is aligned to SETS*WAYS words) reads and writes data word (set, way) of the array. That word still holds the data that the cache held in that line before the flush.
- R6: While the mode is active, an access outside the window returns an error response and changes no stored data.
- R7: A leave pulse in active mode returns the block to normal mode in the next cycle, with no busy cycle and no write-back. Addresses written through the window are not valid cache lines afterwards.
- R8: The second agent port gets the same window read and write access as the CPU while the mode is active. In normal mode its requests return an error.
- R9: When both ports request in the same cycle, only the CPU port is granted. The second agent is granted once the CPU request drops.
- R10: An enter pulse during a flush and a leave pulse while the mode is inactive are ignored.
- R11: In normal mode a CPU write hits an existing line or allocates the lowest invalid way of its set (set = low log2(SETS) address bits). If the set is full, the write returns an error. A read that hits returns the stored data, and a read that misses returns an error.
- R12: No request is granted while `busy_o` is high. Every granted request gets exactly one response on the cycle after its grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_enter_i | input | 1 | Request to enter scratch-memory mode |
| mode_leave_i | input | 1 | Request to leave scratch-memory mode |
| car_active_o | output | 1 | Scratch-memory mode active |
| busy_o | output | 1 | Flush in progress |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | CPU write enable |
| cpu_addr_i | input | AW | CPU word address |
| cpu_wdata_i | input | DW | CPU write data |
| cpu_gnt_o | output | 1 | CPU request accepted this cycle |
| cpu_rvalid_o | output | 1 | CPU response valid |
| cpu_rdata_o | output | DW | CPU read data |
| cpu_err_o | output | 1 | CPU error response |
| dma_req_i | input | 1 | Second-agent access request |
| dma_we_i | input | 1 | Second-agent write enable |
| dma_addr_i | input | AW | Second-agent word address |
| dma_wdata_i | input | DW | Second-agent write data |
| dma_gnt_o | output | 1 | Second-agent request accepted |
| dma_rvalid_o | output | 1 | Second-agent response valid |
| dma_rdata_o | output | DW | Second-agent read data |
| dma_err_o | output | 1 | Second-agent error response |
| wb_valid_o | output | 1 | Write-back of a dirty line pending |
| wb_ready_o | input | 1 | Write-back accepted by memory side |
| wb_addr_o | output | AW | Write-back word address {tag, set} |
| wb_data_o | output | DW | Write-back data |

## Verification
Two functions can fall in the same cycle. A CPU access and a second-agent access may collide, and a mode request may collide with a flush already running. The bench raises both request lines in one cycle in active mode and expects only the CPU grant plus a CPU response, with the second agent served one cycle later. In the middle of a stalled flush it pulses enter and a CPU read together, then judges from the total busy length, the ordered write-back log and the missing response that neither request had any effect.

// File: rtl/car_pkg.sv
package car_pkg;

  typedef enum logic [1:0] {
    M_NORMAL = 2'd0,
    M_FLUSH  = 2'd1,
    M_ACTIVE = 2'd2
  } car_mode_e;

endpackage

// File: rtl/car_window_decode.sv
module car_window_decode #(
  parameter int unsigned AW = 12,
  parameter int unsigned SETS = 4,
  parameter int unsigned WAYS = 2,
  parameter logic [AW-1:0] WIN_BASE = 12'h800,
  localparam int unsigned SB = $clog2(SETS),
  localparam int unsigned WB = $clog2(WAYS),
  localparam int unsigned LB = SB + WB
) (
  input  logic [AW-1:0] addr_i,
  output logic          in_win_o,
  output logic [SB-1:0] set_o,
  output logic [LB-1:0] line_o
);

  function automatic logic [SB-1:0] win_set(input logic [AW-1:0] a);
    return a[SB-1:0];
  endfunction

  function automatic logic [WB-1:0] win_way(input logic [AW-1:0] a);
    return a[LB-1:SB];
  endfunction

  function automatic logic win_match(input logic [AW-1:0] a);
    return a[AW-1:LB] == WIN_BASE[AW-1:LB];
  endfunction

  assign in_win_o = win_match(addr_i);
  assign set_o    = win_set(addr_i);
  assign line_o   = {win_set(addr_i), win_way(addr_i)};

endmodule

// File: rtl/car_arbiter.sv
module car_arbiter (
  input  logic hold_i,
  input  logic cpu_req_i,
  input  logic dma_req_i,
  output logic cpu_gnt_o,
  output logic dma_gnt_o,
  output logic sel_dma_o
);

  assign cpu_gnt_o = cpu_req_i && !hold_i;
  assign dma_gnt_o = dma_req_i && !cpu_req_i && !hold_i;
  assign sel_dma_o = !cpu_req_i;

endmodule

// File: rtl/car_mode_fsm.sv
module car_mode_fsm
  import car_pkg::*;
#(
  parameter int unsigned LINES = 8,
  localparam int unsigned LB = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter_i,
  input  logic          leave_i,
  input  logic          line_dirty_i,
  input  logic          wb_ready_i,
  output logic [LB-1:0] flush_idx_o,
  output logic          line_clear_o,
  output logic          wb_valid_o,
  output logic          busy_o,
  output logic          active_o
);

  localparam logic [LB-1:0] LAST = LB'(LINES - 1);

  car_mode_e     mode_q;
  logic [LB-1:0] idx_q;
  logic          advance;

  assign advance      = (mode_q == M_FLUSH) && (!line_dirty_i || wb_ready_i);
  assign line_clear_o = advance;
  assign wb_valid_o   = (mode_q == M_FLUSH) && line_dirty_i;
  assign busy_o       = (mode_q == M_FLUSH);
  assign active_o     = (mode_q == M_ACTIVE);
  assign flush_idx_o  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_NORMAL;
      idx_q  <= '0;
    end else begin
      unique case (mode_q)
        M_NORMAL: if (enter_i) begin
          mode_q <= M_FLUSH;
          idx_q  <= '0;
        end
        M_FLUSH: if (advance) begin
          if (idx_q == LAST) begin
            mode_q <= M_ACTIVE;
            idx_q  <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        M_ACTIVE: if (leave_i) mode_q <= M_NORMAL;
        default: mode_q <= M_NORMAL;
      endcase
    end
  end

  p_busy_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && active_o));

  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_NORMAL && enter_i) |=> busy_o);

  p_flush_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_clear_o && idx_q != LAST) |=> (busy_o && idx_q == $past(idx_q) + 1'b1));

  p_flush_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(idx_q)));

  p_leave_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && leave_i) |=> (!active_o && !busy_o));

  p_leave_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_NORMAL && leave_i && !enter_i) |=> (mode_q == M_NORMAL));

endmodule

// File: rtl/car_ram_ctrl.sv
module car_ram_ctrl #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16,
  parameter int unsigned SETS = 4,
  parameter int unsigned WAYS = 2,
  parameter logic [AW-1:0] WIN_BASE = 12'h800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_enter_i,
  input  logic          mode_leave_i,
  output logic          car_active_o,
  output logic          busy_o,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_gnt_o,
  output logic          cpu_rvalid_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          cpu_err_o,
  input  logic          dma_req_i,
  input  logic          dma_we_i,
  input  logic [AW-1:0] dma_addr_i,
  input  logic [DW-1:0] dma_wdata_i,
  output logic          dma_gnt_o,
  output logic          dma_rvalid_o,
  output logic [DW-1:0] dma_rdata_o,
  output logic          dma_err_o,
  output logic          wb_valid_o,
  input  logic          wb_ready_o,
  output logic [AW-1:0] wb_addr_o,
  output logic [DW-1:0] wb_data_o
);

  localparam int unsigned SB    = $clog2(SETS);
  localparam int unsigned WB    = $clog2(WAYS);
  localparam int unsigned LB    = SB + WB;
  localparam int unsigned LINES = SETS * WAYS;
  localparam int unsigned TW    = AW - SB;

  logic [DW-1:0]    data_q [LINES];
  logic [TW-1:0]    tag_q  [LINES];
  logic [LINES-1:0] val_q, dty_q;

  logic [LB-1:0] flush_idx;
  logic          line_clear, line_dirty;

  logic          sel_dma, req_v, a_we, in_win;
  logic [AW-1:0] a_addr;
  logic [DW-1:0] a_wdata;
  logic [SB-1:0] a_set;
  logic [LB-1:0] win_line;
  logic [TW-1:0] a_tag;

  car_mode_fsm #(.LINES(LINES)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .enter_i(mode_enter_i), .leave_i(mode_leave_i),
    .line_dirty_i(line_dirty), .wb_ready_i(wb_ready_o),
    .flush_idx_o(flush_idx), .line_clear_o(line_clear),
    .wb_valid_o(wb_valid_o), .busy_o(busy_o), .active_o(car_active_o)
  );

  car_arbiter u_arb (
    .hold_i(busy_o), .cpu_req_i(cpu_req_i), .dma_req_i(dma_req_i),
    .cpu_gnt_o(cpu_gnt_o), .dma_gnt_o(dma_gnt_o), .sel_dma_o(sel_dma)
  );

  assign req_v   = cpu_gnt_o || dma_gnt_o;
  assign a_we    = sel_dma ? dma_we_i    : cpu_we_i;
  assign a_addr  = sel_dma ? dma_addr_i  : cpu_addr_i;
  assign a_wdata = sel_dma ? dma_wdata_i : cpu_wdata_i;
  assign a_tag   = a_addr[AW-1:SB];

  car_window_decode #(.AW(AW), .SETS(SETS), .WAYS(WAYS), .WIN_BASE(WIN_BASE)) u_dec (
    .addr_i(a_addr), .in_win_o(in_win), .set_o(a_set), .line_o(win_line)
  );

  assign line_dirty = val_q[flush_idx] && dty_q[flush_idx];
  assign wb_addr_o  = {tag_q[flush_idx], flush_idx[LB-1:WB]};
  assign wb_data_o  = data_q[flush_idx];

  // Normal-mode lookup: hit way and lowest invalid way of the set.
  logic          hit, free;
  logic [LB-1:0] hit_line, free_line;

  always_comb begin
    logic [LB-1:0] ln;
    hit = 1'b0; hit_line = '0; free = 1'b0; free_line = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      ln = {a_set, WB'(w)};
      if (val_q[ln] && tag_q[ln] == a_tag) begin
        hit = 1'b1; hit_line = ln;
      end
      if (!val_q[ln]) begin
        free = 1'b1; free_line = ln;
      end
    end
  end

  logic          acc_err, do_wr, wr_alloc;
  logic [DW-1:0] acc_rdata;
  logic [LB-1:0] wr_line;

  always_comb begin
    acc_err = 1'b0; acc_rdata = '0; do_wr = 1'b0; wr_line = '0; wr_alloc = 1'b0;
    if (car_active_o) begin
      if (in_win) begin
        acc_rdata = data_q[win_line];
        do_wr     = a_we;
        wr_line   = win_line;
      end else begin
        acc_err = 1'b1;
      end
    end else if (sel_dma) begin
      acc_err = 1'b1;
    end else if (a_we) begin
      if (hit) begin
        do_wr = 1'b1; wr_line = hit_line;
      end else if (free) begin
        do_wr = 1'b1; wr_line = free_line; wr_alloc = 1'b1;
      end else begin
        acc_err = 1'b1;
      end
    end else if (hit) begin
      acc_rdata = data_q[hit_line];
    end else begin
      acc_err = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (req_v && do_wr) begin
      data_q[wr_line] <= a_wdata;
      if (!car_active_o && wr_alloc) tag_q[wr_line] <= a_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      dty_q <= '0;
      cpu_rvalid_o <= 1'b0; cpu_err_o <= 1'b0; cpu_rdata_o <= '0;
      dma_rvalid_o <= 1'b0; dma_err_o <= 1'b0; dma_rdata_o <= '0;
    end else begin
      if (line_clear) begin
        val_q[flush_idx] <= 1'b0;
        dty_q[flush_idx] <= 1'b0;
      end
      if (req_v && do_wr && !car_active_o) begin
        val_q[wr_line] <= 1'b1;
        dty_q[wr_line] <= 1'b1;
      end
      cpu_rvalid_o <= cpu_gnt_o;
      cpu_err_o    <= cpu_gnt_o && acc_err;
      cpu_rdata_o  <= (cpu_gnt_o && !a_we && !acc_err) ? acc_rdata : '0;
      dma_rvalid_o <= dma_gnt_o;
      dma_err_o    <= dma_gnt_o && acc_err;
      dma_rdata_o  <= (dma_gnt_o && !a_we && !acc_err) ? acc_rdata : '0;
    end
  end

  p_no_tags_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
    car_active_o |-> (val_q == '0));

  p_wb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid_o && !wb_ready_o) |=> ($stable(wb_addr_o) && $stable(wb_data_o)));

  p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_gnt_o && dma_gnt_o));

  p_cpu_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_i && dma_req_i && !busy_o) |=> (cpu_rvalid_o && !dma_rvalid_o));

  p_no_grant_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!cpu_gnt_o && !dma_gnt_o));

  p_one_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!cpu_rvalid_o && !dma_rvalid_o));

endmodule

// File: tb/car_ram_ctrl_test.sv
`timescale 1ns/1ps
module car_ram_ctrl_test;

  localparam int AW = 12, DW = 16, SETS = 4, WAYS = 2, LINES = 8;
  localparam logic [11:0] WBASE = 12'h800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_enter = 0, mode_leave = 0;
  logic car_active, busy;
  logic cpu_req = 0, cpu_we = 0; logic [AW-1:0] cpu_addr = '0; logic [DW-1:0] cpu_wdata = '0;
  logic cpu_gnt, cpu_rvalid, cpu_err; logic [DW-1:0] cpu_rdata;
  logic dma_req = 0, dma_we = 0; logic [AW-1:0] dma_addr = '0; logic [DW-1:0] dma_wdata = '0;
  logic dma_gnt, dma_rvalid, dma_err; logic [DW-1:0] dma_rdata;
  logic wb_valid, wb_ready = 0; logic [AW-1:0] wb_addr; logic [DW-1:0] wb_data;

  int tests = 0, fails = 0;
  bit done = 0;
  int wb_n = 0;
  logic [AW-1:0] wb_log_a [16];
  logic [DW-1:0] wb_log_d [16];

  always #2.5 clk = ~clk;

  car_ram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_enter_i(mode_enter), .mode_leave_i(mode_leave),
    .car_active_o(car_active), .busy_o(busy),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_gnt_o(cpu_gnt), .cpu_rvalid_o(cpu_rvalid), .cpu_rdata_o(cpu_rdata), .cpu_err_o(cpu_err),
    .dma_req_i(dma_req), .dma_we_i(dma_we), .dma_addr_i(dma_addr), .dma_wdata_i(dma_wdata),
    .dma_gnt_o(dma_gnt), .dma_rvalid_o(dma_rvalid), .dma_rdata_o(dma_rdata), .dma_err_o(dma_err),
    .wb_valid_o(wb_valid), .wb_ready_o(wb_ready), .wb_addr_o(wb_addr), .wb_data_o(wb_data)
  );

  always @(posedge clk) begin
    if (wb_valid && wb_ready && wb_n < 16) begin
      wb_log_a[wb_n] = wb_addr;
      wb_log_d[wb_n] = wb_data;
      wb_n++;
    end
  end

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return DW'(16'h1000 ^ (32'(a) * 7));
  endfunction

  // Window address for a (set, way) pair: offset = way*SETS + set.
  function automatic logic [AW-1:0] waddr(input int set, input int way);
    return WBASE + AW'(way * SETS + set);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit dma, input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic g, output logic rv,
                        output logic [DW-1:0] rd, output logic er);
    @(negedge clk);
    if (dma) begin dma_req = 1; dma_we = we; dma_addr = a; dma_wdata = d; end
    else     begin cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; end
    #1 g = dma ? dma_gnt : cpu_gnt;
    @(negedge clk);
    rv = dma ? dma_rvalid : cpu_rvalid;
    rd = dma ? dma_rdata : cpu_rdata;
    er = dma ? dma_err : cpu_err;
    cpu_req = 0; dma_req = 0;
  endtask

  task automatic expect_ok(input string req, input bit dma, input bit we,
                           input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [DW-1:0] exp_rd);
    logic g, rv, er; logic [DW-1:0] rd;
    access(dma, we, a, d, g, rv, rd, er);
    chk(req, {29'd0, g, rv, er}, 32'b110);
    if (!we) chk(req, 32'(rd), 32'(exp_rd));
  endtask

  task automatic expect_err(input string req, input bit dma, input bit we,
                            input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic g, rv, er; logic [DW-1:0] rd;
    access(dma, we, a, d, g, rv, rd, er);
    chk(req, {29'd0, g, rv, er}, 32'b111);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] win [LINES];
    int cnt, wb0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset", {28'd0, car_active, busy, wb_valid, cpu_rvalid | dma_rvalid}, 32'd0);

    // R11: normal-mode cache behaviour; set = addr[1:0]
    expect_ok("R11 alloc way0", 0, 1, 12'h010, pat(12'h010), '0);
    expect_ok("R11 alloc way1", 0, 1, 12'h014, pat(12'h014), '0);
    expect_err("R11 set full", 0, 1, 12'h018, 16'h0);
    expect_ok("R11 alloc set3", 0, 1, 12'h013, pat(12'h013), '0);
    expect_ok("R11 read hit", 0, 0, 12'h010, '0, pat(12'h010));
    expect_ok("R11 read hit way1", 0, 0, 12'h014, '0, pat(12'h014));
    expect_err("R11 read miss", 0, 0, 12'h030, '0);
    expect_err("R8 dma normal", 1, 0, 12'h010, '0);

    // R10: leave while inactive is ignored
    @(negedge clk); mode_leave = 1;
    @(negedge clk); mode_leave = 0;
    chk("R10 leave idle", {30'd0, car_active, busy}, 32'd0);
    expect_ok("R10 state kept", 0, 0, 12'h013, '0, pat(12'h013));

    // R2/R3/R10/R12: flush with three stall cycles and interfering requests
    wb_ready = 0;
    @(negedge clk); mode_enter = 1;
    @(negedge clk); mode_enter = 0;
    chk("R2 busy after enter", {30'd0, busy, car_active}, 32'b10);
    cnt = 1; wb_ready = 0;
    forever begin
      @(negedge clk);
      if (!busy) break;
      cnt++;
      wb_ready = (cnt > 3);
      if (cnt == 2) begin
        mode_enter = 1; cpu_req = 1; cpu_we = 0; cpu_addr = 12'h010;
        #1 chk("R12 no grant in flush", 32'(cpu_gnt), 32'd0);
      end
      if (cnt == 3) begin
        mode_enter = 0; cpu_req = 0;
        chk("R12 no response in flush", 32'(cpu_rvalid), 32'd0);
      end
      if (cnt > 40) break;
    end
    wb_ready = 0;
    chk("R3 flush length", 32'(cnt), 32'(LINES + 3));
    chk("R2 active after flush", {30'd0, car_active, busy}, 32'b10);
    chk("R3 writeback count", 32'(wb_n), 32'd3);
    chk("R3 wb0 addr", 32'(wb_log_a[0]), 32'h010);
    chk("R3 wb0 data", 32'(wb_log_d[0]), 32'(pat(12'h010)));
    chk("R3 wb1 addr", 32'(wb_log_a[1]), 32'h014);
    chk("R3 wb2 addr", 32'(wb_log_a[2]), 32'h013);
    chk("R3 wb2 data", 32'(wb_log_d[2]), 32'(pat(12'h013)));

    // R5: window layout, data kept from the cache lines
    expect_ok("R5 set0 way0", 0, 0, waddr(0, 0), '0, pat(12'h010));
    expect_ok("R5 set0 way1", 0, 0, waddr(0, 1), '0, pat(12'h014));
    expect_ok("R5 set3 way0", 1, 0, waddr(3, 0), '0, pat(12'h013));

    // R5/R8: sweep all window words, CPU writes and DMA reads, then the reverse
    for (int i = 0; i < LINES; i++) begin
      win[i] = DW'(16'hA500 + i * 3);
      expect_ok("R5 cpu write", 0, 1, WBASE + AW'(i), win[i], '0);
    end
    for (int i = 0; i < LINES; i++)
      expect_ok("R8 dma read", 1, 0, WBASE + AW'(i), '0, win[i]);
    for (int i = 0; i < LINES; i += 2) begin
      win[i] = DW'(16'h5A00 ^ i);
      expect_ok("R8 dma write", 1, 1, WBASE + AW'(i), win[i], '0);
    end
    for (int i = 0; i < LINES; i++)
      expect_ok("R8 cpu read back", 0, 0, WBASE + AW'(i), '0, win[i]);

    // R6: outside window
    expect_err("R6 read outside", 0, 0, 12'h010, '0);
    expect_err("R6 write outside", 0, 1, 12'h7FF, 16'hDEAD);
    expect_err("R6 dma outside", 1, 1, 12'h808, 16'hBEEF);
    expect_ok("R6 window intact", 0, 0, WBASE + 12'd7, '0, win[7]);

    // R9: simultaneous requests
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = WBASE + 12'd1;
    dma_req = 1; dma_we = 0; dma_addr = WBASE + 12'd2;
    #1 chk("R9 grants", {30'd0, cpu_gnt, dma_gnt}, 32'b10);
    @(negedge clk);
    chk("R9 cpu first", {30'd0, cpu_rvalid, dma_rvalid}, 32'b10);
    chk("R9 cpu data", 32'(cpu_rdata), 32'(win[1]));
    cpu_req = 0;
    #1 chk("R9 dma next", 32'(dma_gnt), 32'd1);
    @(negedge clk);
    dma_req = 0;
    chk("R9 dma data", {15'd0, dma_rvalid, dma_rdata}, {15'd0, 1'b1, win[2]});

    // R7: leave, no flush
    wb0 = wb_n;
    @(negedge clk); mode_leave = 1;
    @(negedge clk); mode_leave = 0;
    chk("R7 leave one cycle", {30'd0, car_active, busy}, 32'd0);
    @(negedge clk);
    chk("R7 no writeback", 32'(wb_n - wb0), 32'd0);
    expect_err("R4 old line invalid", 0, 0, 12'h010, '0);
    expect_err("R7 window not cached", 0, 0, WBASE, '0);
    expect_ok("R7 alloc free way", 0, 1, WBASE, 16'h7E57, '0);
    expect_ok("R7 read alloc", 0, 0, WBASE, '0, 16'h7E57);

    // R3: flush without stalls, one dirty line
    wb0 = wb_n; wb_ready = 1;
    @(negedge clk); mode_enter = 1;
    @(negedge clk); mode_enter = 0;
    cnt = 1;
    forever begin
      @(negedge clk);
      if (!busy) break;
      cnt++;
      if (cnt > 40) break;
    end
    chk("R3 clean flush length", 32'(cnt), 32'(LINES));
    chk("R3 single writeback", 32'(wb_n - wb0), 32'd1);
    chk("R3 writeback addr", 32'(wb_log_a[wb0]), 32'(WBASE));
    chk("R2 active again", 32'(car_active), 32'd1);
    expect_ok("R5 data kept", 0, 0, WBASE, '0, 16'h7E57);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule